// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Port

This block moves stereo audio between a serial link and parallel sample words. It is built for three serial data lines in each direction. Every line shares one bit clock and one word-select (LR) clock, and these clocks come in on pins whether the link runs as master or slave. The block samples the clocks and data pins with its own system clock. It finds the bit-clock edges and counts bit positions from the last LR change. On the receive side it collects the left word and then the right word of each frame. On the transmit side it shifts parallel words out MSB first.

Three static inputs set the framing, the word length and the slot size. The framing is I2S, left-justified or right-justified. The word length is 16, 18, 20 or 24 bits. The slot size is 16 or 32 bit clocks per channel. Receive and transmit always use the same settings. Received words come out sign-extended to 24 bits, with a one-cycle strobe once each frame is complete. Transmit words are taken in once per frame, at the start of the left slot.

Top module: `sap_port`

## Requirements
- R1: While reset is asserted and after its release, before any bit-clock edge, every receive word output is zero, the valid strobe is low and every serial output is low.
- R2: Format code 1 is left-justified. LR high marks the left slot. The MSB is carried on the first bit after an LR change.
- R3: Format code 0 is I2S. LR low marks the left slot. The MSB is carried one bit clock after the LR change. When the word fills the whole slot, its LSB is carried on the first bit of the following slot.
- R4: Format code 2 is right-justified. LR high marks the left slot. The LSB is carried on the last bit clock before the next LR change.
- R5: With 32-clock slots (slot select 1), length code 0, 1, 2 or 3 selects a 16, 18, 20 or 24-bit word. With 16-clock slots (slot select 0), the word is 16 bits whatever the length code.
- R6: A received word is sign-extended from its length to 24 bits. The left and right words of a frame appear together on the outputs, with a strobe that lasts one system cycle and follows the rise on which the right word's last bit was sampled. At all other times the outputs hold their values.
- R7: Received bits in slot positions outside the data word have no effect on the received words.
- R8: On transmit, only the low word-length bits of each parallel word are sent, MSB first. Both words are captured at the first bit-clock fall of the left slot. Slot positions outside the word are driven low.
- R9: Input data and LR are sampled on the bit-clock rise. Serial outputs change only after a bit-clock fall.
- R10: The three receive lines and the three transmit lines carry independent data, and each is placed correctly under the shared clocks.
- R11: Any change of LR seen at a bit-clock rise restarts the bit position at zero. The channel is always left first, then right, within a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Word-select clock |
| sdin_i | input | 3 | Serial receive data lines |
| fmt_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified |
| wlen_i | input | 2 | Word length code: 0=16, 1=18, 2=20, 3=24 |
| wide_i | input | 1 | 1 = 32-clock slots, 0 = 16-clock slots |
| tx_left_i | input | 72 | Left transmit words, 24 bits per line, line 0 in the low bits |
| tx_right_i | input | 72 | Right transmit words, same packing |
| sdout_o | output | 3 | Serial transmit data lines |
| rx_left_o | output | 72 | Received left words, sign-extended |
| rx_right_o | output | 72 | Received right words, sign-extended |
| rx_valid_o | output | 1 | One-cycle strobe when a frame is complete |

## Verification
The assertions check four things on every cycle. The serial outputs move only after a detected bit-clock fall. Positions outside the word transmit zero. The frame strobe never lasts more than one cycle. The received words never change without it. Bit placement can only be shown by the bench scenarios, because it depends on whole frames: where each framing puts its MSB and LSB, the I2S LSB spilling into the next slot, sign extension at each word length, 16-bit slots forcing 16-bit words, junk bits outside the word, and distinct data on each line.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam logic [1:0] FMT_I2S = 2'd0;
  localparam logic [1:0] FMT_LJ  = 2'd1;
  localparam logic [1:0] FMT_RJ  = 2'd2;

  // number of data bits in a word for the given length code and slot size
  function automatic logic [5:0] word_bits(input logic [1:0] code, input logic wide);
    logic [5:0] n;
    if (!wide) n = 6'd16;
    else begin
      case (code)
        2'd0:    n = 6'd16;
        2'd1:    n = 6'd18;
        2'd2:    n = 6'd20;
        default: n = 6'd24;
      endcase
    end
    return n;
  endfunction

  function automatic logic [5:0] slot_bits(input logic wide);
    return wide ? 6'd32 : 6'd16;
  endfunction

  // slot position of the MSB
  function automatic logic [5:0] lead_bits(input logic [1:0] fmt, input logic [5:0] slot,
                                           input logic [5:0] wbits);
    logic [5:0] p;
    if (fmt == FMT_I2S)     p = 6'd1;
    else if (fmt == FMT_RJ) p = slot - wbits;
    else                    p = 6'd0;
    return p;
  endfunction
endpackage

// File: rtl/sap_edge.sv
module sap_edge #(
  parameter int NLINE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_i,
  input  logic             lrck_i,
  input  logic [NLINE-1:0] sdin_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             lr_o,
  output logic [NLINE-1:0] sd_o
);
  logic             bck_q, bck_d_q, lr_q;
  logic [NLINE-1:0] sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q   <= 1'b0;
      bck_d_q <= 1'b0;
      lr_q    <= 1'b0;
      sd_q    <= '0;
    end else begin
      bck_q   <= bclk_i;
      bck_d_q <= bck_q;
      lr_q    <= lrck_i;
      sd_q    <= sdin_i;
    end
  end

  always_comb begin
    rise_o = bck_q & ~bck_d_q;
    fall_o = ~bck_q & bck_d_q;
    lr_o   = lr_q;
    sd_o   = sd_q;
  end
endmodule

// File: rtl/sap_slot_ctr.sv
module sap_slot_ctr
  import sap_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             lr_i,
  input  logic [1:0]       fmt_i,
  input  logic [1:0]       wlen_i,
  input  logic             wide_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             left_o,
  output logic             in_word_o,
  output logic             last_o,
  output logic             cap_o,
  output logic [5:0]       lead_o,
  output logic [5:0]       wbits_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, idx;
  logic             lr_last_q, lr_last_d;
  logic             valid_q, valid_d;
  logic             raw_left;
  logic [5:0]       slot, wbits, lead;
  logic [CNT_W:0]   pos_x, lead_x, end_x;

  always_comb begin
    slot  = slot_bits(wide_i);
    wbits = word_bits(wlen_i, wide_i);
    lead  = lead_bits(fmt_i, slot, wbits);
    if (lr_i != lr_last_q)    idx = '0;
    else if (cnt_q == CNT_MAX) idx = cnt_q;
    else                       idx = cnt_q + 1'b1;
    raw_left = (fmt_i == FMT_I2S) ? ~lr_i : lr_i;
    // in I2S the first bit of a slot still belongs to the previous channel
    if (fmt_i == FMT_I2S && idx == '0) begin
      pos_o  = CNT_W'(slot);
      left_o = ~raw_left;
    end else begin
      pos_o  = idx;
      left_o = raw_left;
    end
    pos_x     = {1'b0, pos_o};
    lead_x    = (CNT_W+1)'(lead);
    end_x     = (CNT_W+1)'(lead) + (CNT_W+1)'(wbits);
    in_word_o = (pos_x >= lead_x) && (pos_x < end_x);
    last_o    = (pos_x == end_x - 1'b1);
    cap_o     = fall_i && (idx == '0) && raw_left;
    lead_o    = lead;
    wbits_o   = wbits;
    cnt_d     = rise_i ? idx : cnt_q;
    lr_last_d = rise_i ? lr_i : lr_last_q;
    valid_d   = rise_i && last_o && !left_o;
    valid_o   = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lr_last_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      lr_last_q <= lr_last_d;
      valid_q   <= valid_d;
    end
  end
endmodule

// File: rtl/sap_rx_lane.sv
module sap_rx_lane #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              sd_i,
  input  logic              in_word_i,
  input  logic              last_i,
  input  logic              left_i,
  input  logic [5:0]        wbits_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o
);
  logic [WORD_W-1:0] sh_q, sh_n, hold_q, l_q, r_q;
  logic signed [WORD_W-1:0] aligned, word;
  logic [5:0] shamt;
  logic       sh_en, done;

  always_comb begin
    sh_n    = {sh_q[WORD_W-2:0], sd_i};
    shamt   = 6'(WORD_W) - wbits_i;
    aligned = $signed(sh_n << shamt);
    word    = aligned >>> shamt;
    sh_en   = rise_i && in_word_i;
    done    = rise_i && last_i;
    left_o  = l_q;
    right_o = r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hold_q <= '0;
      l_q    <= '0;
      r_q    <= '0;
    end else begin
      if (sh_en) sh_q <= sh_n;
      if (done && left_i) hold_q <= word;
      if (done && !left_i) begin
        l_q <= hold_q;
        r_q <= word;
      end
    end
  end
endmodule

// File: rtl/sap_tx_lane.sv
module sap_tx_lane #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              cap_i,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic [5:0]        lead_i,
  input  logic [5:0]        wbits_i,
  input  logic              in_word_i,
  input  logic              left_i,
  input  logic [WORD_W-1:0] tx_left_i,
  input  logic [WORD_W-1:0] tx_right_i,
  output logic              sdo_o
);
  localparam int IX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] hold_l_q, hold_r_q, src;
  logic [5:0]        ofs;
  logic [IX_W-1:0]   bit_ix;
  logic              sdo_q, sdo_d;

  always_comb begin
    if (left_i) src = cap_i ? tx_left_i : hold_l_q;
    else        src = hold_r_q;
    ofs    = wbits_i - 6'd1 - (6'(pos_i) - lead_i);
    bit_ix = IX_W'(ofs);
    sdo_d  = in_word_i ? src[bit_ix] : 1'b0;
    sdo_o  = sdo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      sdo_q    <= 1'b0;
    end else begin
      if (cap_i) begin
        hold_l_q <= tx_left_i;
        hold_r_q <= tx_right_i;
      end
      if (fall_i) sdo_q <= sdo_d;
    end
  end

  p_pad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && !in_word_i) |=> !sdo_o);
  p_out_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(fall_i));
endmodule

// File: rtl/sap_port.sv
module sap_port #(
  parameter int NLINE  = 3,
  parameter int WORD_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bclk_i,
  input  logic                    lrck_i,
  input  logic [NLINE-1:0]        sdin_i,
  input  logic [1:0]              fmt_i,
  input  logic [1:0]              wlen_i,
  input  logic                    wide_i,
  input  logic [NLINE*WORD_W-1:0] tx_left_i,
  input  logic [NLINE*WORD_W-1:0] tx_right_i,
  output logic [NLINE-1:0]        sdout_o,
  output logic [NLINE*WORD_W-1:0] rx_left_o,
  output logic [NLINE*WORD_W-1:0] rx_right_o,
  output logic                    rx_valid_o
);
  logic             rise, fall, lr;
  logic [NLINE-1:0] sd;
  logic [CNT_W-1:0] pos;
  logic             left, in_word, last, cap;
  logic [5:0]       lead, wbits;

  sap_edge #(.NLINE(NLINE)) u_edge (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrck_i(lrck_i), .sdin_i(sdin_i),
    .rise_o(rise), .fall_o(fall), .lr_o(lr), .sd_o(sd)
  );

  sap_slot_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall), .lr_i(lr),
    .fmt_i(fmt_i), .wlen_i(wlen_i), .wide_i(wide_i),
    .pos_o(pos), .left_o(left), .in_word_o(in_word), .last_o(last), .cap_o(cap),
    .lead_o(lead), .wbits_o(wbits), .valid_o(rx_valid_o)
  );

  for (genvar g = 0; g < NLINE; g++) begin : g_lane
    sap_rx_lane #(.WORD_W(WORD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .sd_i(sd[g]), .in_word_i(in_word),
      .last_i(last), .left_i(left), .wbits_i(wbits),
      .left_o(rx_left_o[g*WORD_W +: WORD_W]), .right_o(rx_right_o[g*WORD_W +: WORD_W])
    );
    sap_tx_lane #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .fall_i(fall), .cap_i(cap), .pos_i(pos),
      .lead_i(lead), .wbits_i(wbits), .in_word_i(in_word), .left_i(left),
      .tx_left_i(tx_left_i[g*WORD_W +: WORD_W]), .tx_right_i(tx_right_i[g*WORD_W +: WORD_W]),
      .sdo_o(sdout_o[g])
    );
  end

  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  p_words_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> ($stable(rx_left_o) && $stable(rx_right_o)));
endmodule

// File: tb/sap_port_tb.sv
module sap_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b1, lrck = 1'b0;
  logic [2:0]  sdin = '0;
  logic [1:0]  fmt = 2'd1, wlen = 2'd3;
  logic        wide = 1'b1;
  logic [71:0] txl = '0, txr = '0;
  logic [2:0]  sdout;
  logic [71:0] rxl, rxr;
  logic        rxv;

  int n_chk = 0, n_bad = 0;
  logic        armed = 1'b0;
  int          ncap = 0;
  logic [71:0] cap_l [0:1];
  logic [71:0] cap_r [0:1];

  logic [23:0] wl [0:1][0:2];
  logic [23:0] wr [0:1][0:2];
  logic        in_s [0:2][0:159];
  logic        ex_s [0:2][0:159];
  logic        got  [0:2][0:159];
  logic        lr_s [0:159];

  always #5 clk = ~clk;

  sap_port u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrck_i(lrck), .sdin_i(sdin),
    .fmt_i(fmt), .wlen_i(wlen), .wide_i(wide), .tx_left_i(txl), .tx_right_i(txr),
    .sdout_o(sdout), .rx_left_o(rxl), .rx_right_o(rxr), .rx_valid_o(rxv)
  );

  always @(negedge clk) begin
    if (armed && rxv) begin
      if (ncap < 2) begin
        cap_l[ncap] <= rxl;
        cap_r[ncap] <= rxr;
      end
      ncap <= ncap + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] mkw(input int a);
    logic [31:0] x;
    x = 32'(a) * 32'h9E37_79B9;
    return x[31:8] ^ {x[15:0], x[31:24]};
  endfunction

  function automatic logic [23:0] sext(input logic [23:0] w, input int n);
    logic signed [23:0] t;
    t = $signed(w << (24 - n));
    return 24'(t >>> (24 - n));
  endfunction

  // one bit clock: low phase carries the new LR and data, output sampled before the rise
  task automatic drive_bit(input logic lr, input logic [2:0] d, output logic [2:0] q);
    @(negedge clk);
    bclk = 1'b0; lrck = lr; sdin = d;
    repeat (3) @(negedge clk);
    q = sdout;
    @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(input string req, input logic [1:0] f, input logic [1:0] lc,
                          input logic wd, input logic junk, input int salt);
    int S, W, nbits;
    logic left_lv;
    logic [2:0] q, d;
    S = wd ? 32 : 16;
    W = !wd ? 16 : (lc == 0 ? 16 : lc == 1 ? 18 : lc == 2 ? 20 : 24);
    nbits = 5 * S;
    left_lv = (f == 2'd0) ? 1'b0 : 1'b1;
    for (int fr = 0; fr < 2; fr++)
      for (int ln = 0; ln < 3; ln++) begin
        wl[fr][ln] = mkw(salt * 31 + fr * 7 + ln * 2 + 1);
        wr[fr][ln] = mkw(salt * 31 + fr * 7 + ln * 2 + 2);
      end
    // serial stream: frame 0, frame 1, then a trailing left slot of zeros
    for (int j = 0; j < nbits; j++) begin
      int sl, k, p;
      logic [23:0] w;
      sl = j / S; k = j % S;
      p = (f == 2'd2) ? k - (S - W) : k;
      lr_s[j] = (sl % 2 == 0) ? left_lv : ~left_lv;
      for (int ln = 0; ln < 3; ln++) begin
        if (sl == 4) w = '0;
        else w = (sl % 2 == 0) ? wl[sl/2][ln] : wr[sl/2][ln];
        if (p >= 0 && p < W) begin
          in_s[ln][j] = w[W-1-p];
          ex_s[ln][j] = w[W-1-p];
        end else begin
          in_s[ln][j] = junk;
          ex_s[ln][j] = 1'b0;
        end
      end
    end
    if (f == 2'd0) begin
      for (int ln = 0; ln < 3; ln++) begin
        for (int j = nbits - 1; j > 0; j--) begin
          in_s[ln][j] = in_s[ln][j-1];
          ex_s[ln][j] = ex_s[ln][j-1];
        end
        in_s[ln][0] = 1'b0;
        ex_s[ln][0] = 1'b0;
      end
    end
    @(negedge clk);
    fmt = f; wlen = lc; wide = wd; txl = '0; txr = '0;
    for (int j = 0; j < S; j++) drive_bit(~left_lv, 3'b000, q);
    ncap = 0;
    for (int j = 0; j < nbits; j++) begin
      if (j % (2 * S) == 0) begin
        for (int ln = 0; ln < 3; ln++) begin
          txl[ln*24 +: 24] = (j / (2 * S) < 2) ? wl[j/(2*S)][ln] : 24'h0;
          txr[ln*24 +: 24] = (j / (2 * S) < 2) ? wr[j/(2*S)][ln] : 24'h0;
        end
      end
      d = {in_s[2][j], in_s[1][j], in_s[0][j]};
      drive_bit(lr_s[j], d, q);
      for (int ln = 0; ln < 3; ln++) got[ln][j] = q[ln];
      if (j == 1) armed = 1'b1;
    end
    repeat (4) @(negedge clk);
    armed = 1'b0;
    check(ncap == 2, req, "frame strobes R6", 32'(ncap), 32'd2);
    for (int fr = 0; fr < 2 && fr < ncap; fr++)
      for (int ln = 0; ln < 3; ln++) begin
        check(cap_l[fr][ln*24 +: 24] == sext(wl[fr][ln], W), req, "rx left R10",
              32'(cap_l[fr][ln*24 +: 24]), 32'(sext(wl[fr][ln], W)));
        check(cap_r[fr][ln*24 +: 24] == sext(wr[fr][ln], W), req, "rx right R10",
              32'(cap_r[fr][ln*24 +: 24]), 32'(sext(wr[fr][ln], W)));
      end
    for (int ln = 0; ln < 3; ln++) begin
      int bad_at;
      bad_at = -1;
      for (int j = nbits - 1; j >= 0; j--) if (got[ln][j] !== ex_s[ln][j]) bad_at = j;
      if (bad_at < 0) check(1'b1, req, "tx R8", 32'd0, 32'd0);
      else check(1'b0, req, $sformatf("tx R8 line %0d bit %0d", ln, bad_at),
                 32'(got[ln][bad_at]), 32'(ex_s[ln][bad_at]));
    end
  endtask

  task automatic reset_case();
    repeat (3) @(negedge clk);
    check(rxl == '0 && rxr == '0, "R1", "rx words in reset", rxl[31:0], 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rxv == 1'b0, "R1", "valid after release", 32'(rxv), 32'd0);
    check(sdout == 3'b000, "R1", "sdout after release", 32'(sdout), 32'd0);
    check(rxl == '0 && rxr == '0, "R1", "rx words after release", rxr[31:0], 32'd0);
  endtask

  logic done = 1'b0;

  initial begin
    reset_case();
    run_case("R2", 2'd1, 2'd3, 1'b1, 1'b0, 1);   // LJ 64fs 24-bit
    run_case("R3", 2'd0, 2'd3, 1'b1, 1'b1, 2);   // I2S 64fs 24-bit, junk fill
    run_case("R4", 2'd2, 2'd0, 1'b1, 1'b1, 3);   // RJ 64fs 16-bit, junk fill R7
    run_case("R5", 2'd2, 2'd2, 1'b1, 1'b0, 4);   // RJ 64fs 20-bit
    run_case("R7", 2'd1, 2'd1, 1'b1, 1'b1, 5);   // LJ 64fs 18-bit, junk fill
    run_case("R3", 2'd0, 2'd3, 1'b0, 1'b0, 6);   // I2S 32fs, LSB spills, R5 forced 16
    run_case("R4", 2'd2, 2'd1, 1'b0, 1'b1, 7);   // RJ 32fs
    run_case("R11", 2'd1, 2'd2, 1'b0, 1'b0, 8);  // LJ 32fs, restart on LR change
    run_case("R9", 2'd0, 2'd1, 1'b1, 1'b0, 9);   // I2S 64fs 18-bit
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule